// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is a per-core local timer. Software sets it up through a small register port. In the countdown modes, a current count runs down at a divided clock rate. When the count expires, the block raises a one-cycle interrupt request that carries the 8-bit vector held in the control register. A one-shot timer stops at zero. A periodic timer reloads from its initial count.

In deadline mode the countdown freezes. The block instead compares a free-running 64-bit timestamp input against a deadline register. It fires once when the timestamp reaches the deadline, then clears the deadline.

Changing the mode never touches the running count or the initial count, so counting carries on from wherever it stands. Priority masking and interrupt delivery are outside this block.

The interrupt output is a plain pulse with no ready input and no back-pressure. A request that downstream logic does not capture in that cycle is lost, so the consumer must accept a pulse on any cycle.

Register map (the `wr_addr` / `rd_addr` value is given first):

- 0, control: bits [7:0] hold the vector and bits [9:8] hold the mode. Mode 0 is one-shot, 1 is periodic, 2 is deadline, and 3 behaves as one-shot.
- 1, initial count: 32 bits.
- 2, current count: read-only.
- 3, divide configuration: 4 bits.
- 4, deadline: 64 bits.

Reads are combinational on `rd_addr`. Unmapped addresses read as zero.

Top module: `cdtimer_top`

## Requirements
- R1: After reset every register reads zero, `irq_pulse` is low and `irq_vector` is zero.
- R2: A write to address 1 sets the initial count and loads the current count with the same value, visible after that clock edge. Each later divided tick lowers a nonzero current count by one. A write to address 2 has no effect.
- R3: The divide configuration selects the tick rate. With code = {bit3, bit1, bit0}, code 3'b111 (for example 0xB) ticks every cycle, and any other code divides the clock by 2^(code+1). For example, 0x0 ticks every second cycle.
- R4: In one-shot mode, the tick that takes the count from 1 to 0 raises exactly one interrupt. The count then stays at zero.
- R5: In periodic mode, the tick that would take the count to 0 raises an interrupt and reloads the count from the initial count. The period is therefore the initial count in ticks.
- R6: A write to the control register changes neither the initial count nor the current count, and counting continues from the present value.
- R7: Switching to periodic mode while the current count is zero leaves it at zero with no interrupt, even when the initial count is nonzero.
- R8: Switching from periodic to one-shot mid-count lets the count run down to zero, raise one interrupt and stop.
- R9: In deadline mode, a nonzero deadline at or below `ts_in` raises one interrupt on the next clock edge and clears the deadline to zero. A future deadline fires once, when the timestamp reaches it.
- R10: Writing an initial count of zero stops the timer without an interrupt.
- R11: `irq_pulse` is high for one cycle per expiry, and `irq_vector` carries the control vector in that cycle and is zero in other cycles.
- R12: In deadline mode the current count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 64 | Register read data (combinational) |
| ts_in | input | 64 | Free-running timestamp |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector for the request, zero otherwise |

## Verification
Faults in the count register become visible the next time the current count is read. The bench reads it on every clock, so a skipped decrement or a wrong reload after a mode change shows up within one cycle.

Faults in the prescaler phase or in the deadline comparison show up more slowly. They appear as an interrupt pulse that is early, late or missing at the expiry edge, and as a deadline that fails to read back zero one cycle after it fires.

A reference model compares the pulse and its vector on every edge. As a result, a lost, duplicated or mis-vectored request is caught in the cycle it occurs.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2,
    MODE_RSVD     = 2'd3
  } tmr_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_INIT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CUR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DLINE = 3'd4;

  localparam int DIV_CFG_W = 4;
  localparam int SHIFT_W   = 3;

  // Code {b3,b1,b0}: 7 -> shift 0 (divide 1), n -> shift n+1.
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_CFG_W-1:0] cfg);
    return {cfg[3], cfg[1:0]} + 3'd1;
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
`timescale 1ns/1ps
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_CFG_W-1:0] div_cfg,
  output logic                 tick
);
  logic [PRE_W-1:0]   pre_cnt;
  logic [PRE_W:0]     mask_w;
  logic [SHIFT_W-1:0] shift;

  always_comb begin
    shift  = div_shift(div_cfg);
    mask_w = ({{PRE_W{1'b0}}, 1'b1} << shift) - 1'b1;
    tick   = (pre_cnt & mask_w[PRE_W-1:0]) == mask_w[PRE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/cdt_countdown.sv
`timescale 1ns/1ps
module cdt_countdown
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cur_cnt,
  output logic [CNT_W-1:0] init_cnt,
  output logic             fire
);
  logic run;
  logic at_one;

  always_comb begin
    run    = (mode != MODE_DEADLINE) && tick && (cur_cnt != '0);
    at_one = (cur_cnt == {{(CNT_W-1){1'b0}}, 1'b1});
    fire   = run && at_one && !load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cnt  <= '0;
      init_cnt <= '0;
    end else if (load_en) begin
      init_cnt <= load_val;
      cur_cnt  <= load_val;
    end else if (run) begin
      if (at_one) cur_cnt <= (mode == MODE_PERIODIC) ? init_cnt : '0;
      else        cur_cnt <= cur_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cdt_deadline.sv
`timescale 1ns/1ps
module cdt_deadline #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dl_mode,
  input  logic [TS_W-1:0] ts_in,
  input  logic            wr_en,
  input  logic [TS_W-1:0] wr_val,
  output logic [TS_W-1:0] dl_q,
  output logic            fire
);
  logic hit;

  always_comb begin
    hit  = dl_mode && (dl_q != '0) && (ts_in >= dl_q);
    fire = hit && !wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dl_q <= '0;
    else if (wr_en)  dl_q <= wr_val;
    else if (hit)    dl_q <= '0;
  end
endmodule

// File: rtl/cdtimer_top.sv
`timescale 1ns/1ps
module cdtimer_top
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TS_W   = 64,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [TS_W-1:0]   ts_in,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam int PRE_W = 7;
  localparam int CTRL_W = VEC_W + 2;

  tmr_mode_e            mode_q;
  logic [VEC_W-1:0]     vec_q;
  logic [DIV_CFG_W-1:0] div_q;
  logic                 tick;
  logic [CNT_W-1:0]     cur_cnt, init_cnt;
  logic [TS_W-1:0]      dl_q;
  logic                 cd_fire, dl_fire;
  logic                 wr_ctrl, wr_init, wr_div, wr_dl;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == A_CTRL);
    wr_init = wr_en && (wr_addr == A_INIT);
    wr_div  = wr_en && (wr_addr == A_DIV);
    wr_dl   = wr_en && (wr_addr == A_DLINE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ONESHOT;
      vec_q  <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        vec_q  <= wr_data[VEC_W-1:0];
        mode_q <= tmr_mode_e'(wr_data[CTRL_W-1:VEC_W]);
      end
      if (wr_div) div_q <= wr_data[DIV_CFG_W-1:0];
    end
  end

  cdt_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_q), .tick(tick)
  );

  cdt_countdown #(.CNT_W(CNT_W)) cd_i (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick),
    .load_en(wr_init), .load_val(wr_data[CNT_W-1:0]),
    .cur_cnt(cur_cnt), .init_cnt(init_cnt), .fire(cd_fire)
  );

  cdt_deadline #(.TS_W(TS_W)) dl_i (
    .clk(clk), .rst_n(rst_n), .dl_mode(mode_q == MODE_DEADLINE),
    .ts_in(ts_in), .wr_en(wr_dl), .wr_val(wr_data[TS_W-1:0]),
    .dl_q(dl_q), .fire(dl_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse  <= cd_fire || dl_fire;
      irq_vector <= (cd_fire || dl_fire) ? vec_q : '0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[CTRL_W-1:0]    = {mode_q, vec_q};
      A_INIT:  rd_data[CNT_W-1:0]     = init_cnt;
      A_CUR:   rd_data[CNT_W-1:0]     = cur_cnt;
      A_DIV:   rd_data[DIV_CFG_W-1:0] = div_q;
      A_DLINE: rd_data[TS_W-1:0]      = dl_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cdtimer_checker.sv
`timescale 1ns/1ps
module cdtimer_checker
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_init,
  input logic             wr_ctrl,
  input logic             wr_dl,
  input logic [CNT_W-1:0] init_wdata,
  input logic [TS_W-1:0]  ts_in,
  input logic             irq_pulse,
  input tmr_mode_e        mode,
  input logic             tick,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] init,
  input logic [TS_W-1:0]  dl
);
  AST_ONESHOT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ONESHOT && cur == '0 && !wr_init) |=> cur == '0); // R4

  AST_PERIODIC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PERIODIC && tick && cur == 1 && !wr_init) |=> (irq_pulse && cur == $past(init))); // R5

  AST_CTRL_KEEPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wr_init) |=> $stable(init)); // R6

  AST_PERIODIC_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PERIODIC && cur == '0 && !wr_init) |=> (cur == '0 && !irq_pulse)); // R7

  AST_DEADLINE_FIRES_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DEADLINE && dl != '0 && ts_in >= dl && !wr_dl) |=> (irq_pulse && dl == '0)); // R9

  AST_ZERO_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && init_wdata == '0) |=> (cur == '0 && !irq_pulse)); // R10

  AST_DEADLINE_FREEZES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DEADLINE && !wr_init) |=> $stable(cur)); // R12
endmodule

bind cdtimer_top cdtimer_checker #(.CNT_W(CNT_W), .TS_W(TS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_init(wr_init), .wr_ctrl(wr_ctrl), .wr_dl(wr_dl),
  .init_wdata(wr_data[CNT_W-1:0]), .ts_in(ts_in), .irq_pulse(irq_pulse),
  .mode(mode_q), .tick(tick), .cur(cur_cnt), .init(init_cnt), .dl(dl_q)
);

// File: tb/cdtimer_top_tb_top.sv
`timescale 1ns/1ps
module cdtimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd2;
  logic [63:0] rd_data;
  logic [63:0] ts_in = 64'd1000;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  cdtimer_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ts_in(ts_in),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int pc = 0;
  logic [7:0] last_vec = '0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  logic [7:0]  m_vec = '0;
  logic [1:0]  m_mode = '0;
  logic [31:0] m_init = '0, m_cur = '0;
  logic [3:0]  m_div = '0;
  logic [63:0] m_dl = '0;
  int          m_pre = 0;
  logic        m_irq = 1'b0;
  logic [7:0]  m_ivec = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {54'd0, m_mode, m_vec};
      3'd1: return {32'd0, m_init};
      3'd2: return {32'd0, m_cur};
      3'd3: return {60'd0, m_div};
      3'd4: return m_dl;
      default: return 64'd0;
    endcase
  endfunction

  task automatic model_update();
    int sh, mask;
    bit tk, fire;
    logic [7:0] ovec;
    logic [1:0] omode;
    fire = 0;
    ovec = m_vec;
    omode = m_mode;
    sh = ({m_div[3], m_div[1:0]} + 1) % 8;
    mask = (1 << sh) - 1;
    tk = (m_pre & mask) == mask;
    if (wr_en && wr_addr == 3'd1) begin
      m_init = wr_data[31:0];
      m_cur = wr_data[31:0];
    end else if (omode != 2'd2 && tk && m_cur != 0) begin
      if (m_cur == 1) begin
        fire = 1;
        m_cur = (omode == 2'd1) ? m_init : 32'd0;
      end else m_cur = m_cur - 1;
    end
    if (wr_en && wr_addr == 3'd4) m_dl = wr_data;
    else if (omode == 2'd2 && m_dl != 0 && ts_in >= m_dl) begin
      fire = 1;
      m_dl = 0;
    end
    if (wr_en && wr_addr == 3'd0) begin
      m_vec = wr_data[7:0];
      m_mode = wr_data[9:8];
    end
    if (wr_en && wr_addr == 3'd3) m_div = wr_data[3:0];
    m_irq = fire;
    m_ivec = fire ? ovec : 8'd0;
    m_pre = (m_pre + 1) % 128;
  endtask

  task automatic step();
    ts_in = ts_in + 1;
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(cur_req, {63'd0, irq_pulse}, {63'd0, m_irq});
    chk(cur_req, {56'd0, irq_vector}, {56'd0, m_ivec});
    chk(cur_req, rd_data, model_read(rd_addr));
    if (irq_pulse) begin
      pc++;
      last_vec = irq_vector;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic get(input logic [2:0] a, output logic [63:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
    rd_addr = 3'd2;
    #1;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      get(a[2:0], v);
      chk("R1", v, 64'd0);
    end
    chk("R1", {63'd0, irq_pulse}, 64'd0);
    chk("R1", {56'd0, irq_vector}, 64'd0);
    rst_n = 1'b1;

    // R3 divide by one, R2 load and decrement, R4 one-shot
    cur_req = "R2";
    wr(3'd3, 64'hB);
    wr(3'd0, 64'h042);
    pc = 0;
    wr(3'd1, 64'd5);
    get(3'd2, v); chk("R2", v, 64'd5);
    idle(2);
    get(3'd2, v); chk("R3", v, 64'd3);
    wr(3'd2, 64'd99);
    get(3'd2, v); chk("R2", v, 64'd2);
    cur_req = "R4";
    idle(15);
    chk("R4", pc, 1);
    get(3'd2, v); chk("R4", v, 64'd0);
    chk("R11", {56'd0, last_vec}, 64'h42);

    // R3 divide by two
    cur_req = "R3";
    wr(3'd3, 64'h0);
    pc = 0;
    wr(3'd1, 64'd4);
    idle(5);
    chk("R3", pc, 0);
    idle(5);
    chk("R3", pc, 1);
    wr(3'd3, 64'hB);

    // R5 periodic
    cur_req = "R5";
    wr(3'd0, 64'h155);
    pc = 0;
    wr(3'd1, 64'd3);
    idle(30);
    chk("R5", pc, 10);
    get(3'd2, v); chk("R5", v, 64'd3);

    // R11 pulse shape
    cur_req = "R11";
    wr(3'd1, 64'd2);
    idle(1);
    chk("R11", {63'd0, irq_pulse}, 64'd0);
    idle(1);
    chk("R11", {63'd0, irq_pulse}, 64'd1);
    chk("R11", {56'd0, irq_vector}, 64'h55);
    idle(1);
    chk("R11", {56'd0, irq_vector}, 64'd0);

    // R6 / R8 mode change mid count
    cur_req = "R6";
    wr(3'd1, 64'd20);
    idle(5);
    get(3'd2, v); chk("R6", v, 64'd15);
    wr(3'd0, 64'h042);
    get(3'd2, v); chk("R6", v, 64'd14);
    get(3'd1, v); chk("R6", v, 64'd20);
    cur_req = "R8";
    pc = 0;
    idle(20);
    chk("R8", pc, 1);
    get(3'd2, v); chk("R8", v, 64'd0);

    // R7 zero count stays zero in periodic
    cur_req = "R7";
    pc = 0;
    wr(3'd0, 64'h155);
    idle(10);
    get(3'd2, v); chk("R7", v, 64'd0);
    chk("R7", pc, 0);

    // R10 zero initial count stops
    cur_req = "R10";
    wr(3'd1, 64'd10);
    idle(3);
    pc = 0;
    wr(3'd1, 64'd0);
    idle(20);
    chk("R10", pc, 0);
    get(3'd2, v); chk("R10", v, 64'd0);

    // R12 / R9 deadline
    cur_req = "R12";
    wr(3'd0, 64'h2AA);
    wr(3'd1, 64'd7);
    idle(5);
    get(3'd2, v); chk("R12", v, 64'd7);
    cur_req = "R9";
    pc = 0;
    wr(3'd4, ts_in - 64'd5);
    idle(1);
    chk("R9", {63'd0, irq_pulse}, 64'd1);
    chk("R9", {56'd0, irq_vector}, 64'hAA);
    get(3'd4, v); chk("R9", v, 64'd0);
    idle(3);
    chk("R9", pc, 1);
    wr(3'd4, ts_in + 64'd10);
    idle(5);
    chk("R9", pc, 1);
    idle(10);
    chk("R9", pc, 2);
    get(3'd4, v); chk("R9", v, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule